// File: doc/BRIEF.md
# Clock-Chip Host Register Port

This block is the host side of a real-time clock's register space. The host first writes an index byte. The low six bits of that byte pick one of 64 byte locations. The host then reads or writes the picked location through a data strobe. The top bit of the index byte is not part of the address. It is latched onto a separate NMI-mask output.

Locations 0 to 10 belong to the timekeeping and divider logic outside this block. The block forwards accesses to them through a small slot interface. Location 11 is the control byte, and its bits 6, 5 and 4 enable the periodic, alarm and update-ended interrupts. Location 12 is the interrupt status byte, which clears when it is read. Location 13 is the validity byte. Locations 14 to 63 are 50 bytes of general storage.

Periodic, alarm and update-ended pulses from the outside logic set the status flags. An active-high `irq` output reports any flag whose interrupt is enabled.

Top module: `rtc_host_regs`

## Requirements
- R1: An index write (`idx_we`) stores `wdata[5:0]` as the selected address and `wdata[7]` on `nmi_mask`. `wdata[6]` is ignored.
- R2: Addresses 14 to 63 are read/write bytes. A data write (`dat_we`) stores `wdata` there, and `rdata` returns the stored byte.
- R3: For addresses 0 to 10, `ext_addr` equals the selected address, `ext_wdata` equals `wdata`, and `ext_we` is high exactly during a data write. `rdata` returns `ext_rdata`.
- R4: Address 11 is a read/write control byte that also drives `ctrl`. Bit 6 is PIE, bit 5 is AIE and bit 4 is UIE.
- R5: The status byte (address 12) reads {IRQF, PF, AF, UF, 4'b0000}, with IRQF at bit 7. A pulse on `ev_periodic`, `ev_alarm` or `ev_update` sets PF, AF or UF, whatever the enables hold.
- R6: A data read (`dat_re`) of address 12 returns the current flags and clears PF, AF and UF on the following clock edge.
- R7: An event pulse in the same cycle as a status read sets its flag after the clear, so the next read sees it.
- R8: IRQF and `irq` are high exactly when (PF&PIE)|(AF&AIE)|(UF&UIE).
- R9: The validity byte (address 13) reads {VRT, 7'b0}. While `bad_power` is high, VRT is cleared. Otherwise a data read of address 13 sets VRT on the following edge.
- R10: Data writes to addresses 12 and 13 change nothing.
- R11: After reset, the index is 0, `nmi_mask` is 0, the control byte is 0, all flags are 0 and VRT is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index write strobe |
| dat_we | input | 1 | Data write strobe |
| dat_re | input | 1 | Data read strobe (side effects on reads) |
| wdata | input | 8 | Write data for index and data writes |
| rdata | output | 8 | Byte at the selected address |
| nmi_mask | output | 1 | Latched bit 7 of the last index write |
| ext_addr | output | 4 | Slot address toward timekeeping logic |
| ext_we | output | 1 | Slot write strobe |
| ext_wdata | output | 8 | Slot write data |
| ext_rdata | input | 8 | Slot read data |
| ctrl | output | 8 | Control byte |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| bad_power | input | 1 | Contents-invalid indication |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is an event pulse that lands in the very cycle of a clearing status read. The bench raises the read strobe and `ev_update` together on one falling edge. It checks that the read returns the old flags and that the next read shows UF alone.

A second case is `bad_power` held high across a validity read. Here the clear has to win over the set. The bench drives both at once and then reads again with `bad_power` low to see VRT return.

// File: rtl/rtc_host_regs.sv
module rtc_host_regs #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic          dat_we,
  input  logic          dat_re,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          nmi_mask,
  output logic [3:0]    ext_addr,
  output logic          ext_we,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata,
  output logic [DW-1:0] ctrl,
  input  logic          ev_periodic,
  input  logic          ev_alarm,
  input  logic          ev_update,
  input  logic          bad_power,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(11);
  localparam logic [AW-1:0] A_STAT = AW'(12);
  localparam logic [AW-1:0] A_VAL  = AW'(13);
  localparam logic [AW-1:0] A_RAM  = AW'(14);
  localparam int unsigned   NRAM   = (1 << AW) - 14;

  logic [AW-1:0] idx;
  logic          pf, af, uf, vrt;
  logic [DW-1:0] ram [NRAM];
  logic [AW-1:0] ram_off;
  logic          sel_ext, sel_ram, rd_stat, rd_val, irqf;

  assign ram_off   = idx - A_RAM;
  assign sel_ext   = idx < A_CTRL;
  assign sel_ram   = idx >= A_RAM;
  assign rd_stat   = dat_re && idx == A_STAT;
  assign rd_val    = dat_re && idx == A_VAL;

  assign ext_addr  = idx[3:0];
  assign ext_we    = dat_we && sel_ext;
  assign ext_wdata = wdata;

  assign irqf = (pf & ctrl[6]) | (af & ctrl[5]) | (uf & ctrl[4]);
  assign irq  = irqf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      nmi_mask <= 1'b0;
    end else if (idx_we) begin
      idx      <= wdata[AW-1:0];
      nmi_mask <= wdata[DW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (dat_we && idx == A_CTRL) ctrl <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf <= 1'b0;
      af <= 1'b0;
      uf <= 1'b0;
    end else begin
      pf <= (pf & ~rd_stat) | ev_periodic;
      af <= (af & ~rd_stat) | ev_alarm;
      uf <= (uf & ~rd_stat) | ev_update;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vrt <= 1'b1;
    else if (bad_power) vrt <= 1'b0;
    else if (rd_val) vrt <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (dat_we && sel_ram) ram[ram_off] <= wdata;
  end

  always_comb begin
    if (sel_ext)            rdata = ext_rdata;
    else if (sel_ram)       rdata = ram[ram_off];
    else if (idx == A_CTRL) rdata = ctrl;
    else if (idx == A_STAT) rdata = {irqf, pf, af, uf, 4'b0000};
    else                    rdata = {vrt, 7'b0};
  end

  // R6
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ev_periodic && !ev_alarm && !ev_update) |=> (!pf && !af && !uf));

  // R7
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_update |=> uf);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf && !af && !uf) |-> !irq);

  // R9
  vrt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_power |=> !vrt);

  // R10
  val_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx == A_VAL && !bad_power && !dat_re) |=> $stable(vrt));

  // R3
  ext_we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> (idx <= AW'(10)));
endmodule

// File: tb/test_rtc_host_regs.sv
module test_rtc_host_regs;
  logic       clk = 0, rst_n = 0;
  logic       idx_we = 0, dat_we = 0, dat_re = 0;
  logic [7:0] wdata = 0, rdata, ext_wdata, ext_rdata, ctrl;
  logic [3:0] ext_addr;
  logic       nmi_mask, ext_we, irq;
  logic       ev_periodic = 0, ev_alarm = 0, ev_update = 0, bad_power = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign ext_rdata = 8'hA0 | {4'h0, ext_addr};

  rtc_host_regs i_rtc_host_regs (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re),
    .wdata(wdata), .rdata(rdata), .nmi_mask(nmi_mask), .ext_addr(ext_addr),
    .ext_we(ext_we), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ctrl(ctrl),
    .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
    .bad_power(bad_power), .irq(irq));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] v);
    @(negedge clk); idx_we = 1; wdata = v;
    @(negedge clk); idx_we = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); dat_we = 1; wdata = v;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic rd(input logic [7:0] exp, input string req);
    @(negedge clk); dat_re = 1; #1 chk(rdata, exp, req);
    @(negedge clk); dat_re = 0;
  endtask

  task automatic t_reset;
    chk({7'b0, nmi_mask}, 8'h00, "R11 nmi");
    chk({7'b0, irq}, 8'h00, "R11 irq");
    chk({4'h0, ext_addr}, 8'h00, "R11 index");
    set_idx(8'd11); rd(8'h00, "R11 ctrl");
    set_idx(8'd12); rd(8'h00, "R11 flags");
    set_idx(8'd13); rd(8'h80, "R11 VRT");
  endtask

  task automatic t_index;
    set_idx(8'hC5);
    chk({7'b0, nmi_mask}, 8'h01, "R1 nmi set");
    chk({4'h0, ext_addr}, 8'h05, "R1 addr bit6 ignored");
    set_idx(8'h0E);
    chk({7'b0, nmi_mask}, 8'h00, "R1 nmi clear");
  endtask

  task automatic t_ram;
    set_idx(8'd14); wr(8'h3C);
    set_idx(8'd63); wr(8'hE1);
    set_idx(8'd40); wr(8'h77);
    set_idx(8'd14); rd(8'h3C, "R2 addr14");
    set_idx(8'd63); rd(8'hE1, "R2 addr63");
    set_idx(8'd40); rd(8'h77, "R2 addr40");
  endtask

  task automatic t_ext;
    set_idx(8'd3);
    @(negedge clk); dat_we = 1; wdata = 8'h59; #1;
    chk({7'b0, ext_we}, 8'h01, "R3 we");
    chk(ext_wdata, 8'h59, "R3 wdata");
    chk({4'h0, ext_addr}, 8'h03, "R3 addr");
    @(negedge clk); dat_we = 0; #1;
    chk({7'b0, ext_we}, 8'h00, "R3 we low");
    rd(8'hA3, "R3 rdata");
    set_idx(8'd10); rd(8'hAA, "R3 addr10");
    set_idx(8'd11); @(negedge clk); dat_we = 1; wdata = 8'h00; #1;
    chk({7'b0, ext_we}, 8'h00, "R3 no we at 11");
    @(negedge clk); dat_we = 0;
  endtask

  task automatic t_irq;
    set_idx(8'd11); wr(8'h40);
    chk(ctrl, 8'h40, "R4 ctrl port"); rd(8'h40, "R4 ctrl read");
    @(negedge clk); ev_periodic = 1; @(negedge clk); ev_periodic = 0;
    chk({7'b0, irq}, 8'h01, "R8 irq PF&PIE");
    @(negedge clk); ev_alarm = 1; @(negedge clk); ev_alarm = 0;
    set_idx(8'd12); rd(8'hE0, "R5 PF AF IRQF");
    chk({7'b0, irq}, 8'h00, "R6 irq after clear");
    rd(8'h00, "R6 cleared");
    @(negedge clk); ev_alarm = 1; @(negedge clk); ev_alarm = 0;
    chk({7'b0, irq}, 8'h00, "R8 AF without AIE");
    rd(8'h20, "R5 AF only");
  endtask

  task automatic t_same_cycle;
    @(negedge clk); ev_update = 1; @(negedge clk); ev_update = 0;
    @(negedge clk); dat_re = 1; ev_update = 1; #1 chk(rdata, 8'h10, "R7 old value");
    @(negedge clk); dat_re = 0; ev_update = 0;
    rd(8'h10, "R7 event kept");
    rd(8'h00, "R7 then cleared");
    set_idx(8'd11); wr(8'h10);
    @(negedge clk); ev_update = 1; @(negedge clk); ev_update = 0;
    chk({7'b0, irq}, 8'h01, "R8 UF&UIE");
  endtask

  task automatic t_valid;
    set_idx(8'd13);
    @(negedge clk); bad_power = 1; @(negedge clk); bad_power = 0;
    @(negedge clk); dat_re = 1; bad_power = 1; #1 chk(rdata, 8'h00, "R9 cleared");
    @(negedge clk); dat_re = 0; bad_power = 0;
    rd(8'h00, "R9 invalid wins");
    rd(8'h80, "R9 read sets");
    @(negedge clk); bad_power = 1; @(negedge clk); bad_power = 0;
    wr(8'hFF); rd(8'h00, "R10 validity write ignored");
    set_idx(8'd12); wr(8'hFF);
    chk({7'b0, irq}, 8'h01, "R10 UF kept");
    rd(8'h90, "R10 status write ignored");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_index(); t_ram(); t_ext(); t_irq(); t_same_cycle(); t_valid();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule